// File: doc/BRIEF.md
# Cross-Map Response Normalizer

This block normalizes convolution results across feature maps. For one pixel position it takes the values of all maps in turn. Each value `a` of map `m` is then scaled by `(k + alpha*S)^(-beta)`. `S` is the sum of squares of the same-position values in the maps from `m-HALF` to `m+HALF`. Maps outside `0..MAPS-1` add nothing to `S`, so the window is clipped at both ends of the map range. The output has as many maps as the input.

The values of one position are shifted into a register stack, one per cycle. The stack then shifts down by `LANES` entries per cycle, so each of the `LANES` parallel processing elements always reads the same fixed stack slots. Each element computes the squared sum over its window, forms the denominator, and finds the power term. That term comes from a 65-entry mantissa table with linear interpolation and a per-exponent scale table. Both tables are built from `BETA` when the design is elaborated.

A position costs `MAPS + ceil(MAPS/LANES)` cycles. Input is refused while the stack is being consumed.

Top module: `xmap_norm`

## Requirements
- R1: Pixels are signed 16-bit with 8 fraction bits. `K_FIX` is k in unsigned Q8.8 and must be at least 1.0. `ALPHA_FIX` is alpha in unsigned Q0.16. Each result equals `a*(k+alpha*S)^(-BETA)` within 2 LSB plus 0.2 % of the exact value.
- R2: For map `m`, `S` covers maps `max(0,m-HALF)` to `min(MAPS-1,m+HALF)`, with `HALF=(WIN-1)/2`. Positions outside the map range contribute zero.
- R3: Each position yields exactly `MAPS` results. Lanes whose mask bit is 0 carry the value 0.
- R4: Results for a position leave in ascending map order, in `ceil(MAPS/LANES)` consecutive valid cycles. `out_first` is the map index of lane 0, starting at 0 and rising by `LANES` each cycle. `out_mask` bit `j` is 1 when map `out_first+j` is below `MAPS`. The set lanes are contiguous from lane 0, and the mask is 0 when `out_valid` is low.
- R5: After the last map of a position is accepted, `in_ready` is low for exactly `ceil(MAPS/LANES)` cycles. Pixels offered while `in_ready` is low are ignored.
- R6: Positions fed back to back give the same results as positions fed in isolation.
- R7: After reset, `out_valid` is 0 and `in_ready` is 1.
- R8: A zero input pixel gives exactly 0. A negative input gives a result of 0 or below, with a magnitude no larger than the input.
- R9: Full-scale inputs of +32767 and -32768 give results within the R1 tolerance, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input pixel is offered |
| in_pixel | input | 16 | Input pixel, signed Q7.8; the maps of a position arrive in order 0..MAPS-1 |
| in_ready | output | 1 | The unit accepts a pixel this cycle |
| out_valid | output | 1 | A group of results is present |
| out_first | output | clog2(MAPS) | Map index of lane 0 |
| out_mask | output | LANES | Lane valid bits |
| out_pixel | output | 16*LANES | Results, lane j in bits 16j+15..16j |

## Verification
The hardest case to reach is the point where results of one position are still draining while the stack is being cleared and reloaded for the next. Any value left over in the stack would only show up in the boundary maps of the following position. The stimulus sends a position with a large spike in map 0 directly followed by a uniform position. The uniform results, including maps 0 to 2, are then checked. A second test holds `in_valid` high with a full-scale value throughout the stall, so that any leak of ignored input would change the checked results.

// File: rtl/xmap_norm.sv
module xmap_norm #(
  parameter int MAPS = 8,
  parameter int WIN = 5,
  parameter int LANES = 2,
  parameter logic [15:0] K_FIX = 16'h0200,
  parameter logic [15:0] ALPHA_FIX = 16'h2000,
  parameter real BETA = 0.75,
  localparam int MW = (MAPS > 1) ? $clog2(MAPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [15:0]    in_pixel,
  output logic                  in_ready,
  output logic                  out_valid,
  output logic [MW-1:0]         out_first,
  output logic [LANES-1:0]      out_mask,
  output logic [16*LANES-1:0]   out_pixel
);
  localparam int HALF = (WIN - 1) / 2;
  localparam int PADN = MAPS + 2 * HALF;
  localparam int GRPS = (MAPS + LANES - 1) / LANES;
  localparam int CW = $clog2(MAPS + 1);
  localparam int GW = $clog2(GRPS + 1);
  localparam int SUMW = 31 + $clog2(WIN + 1);
  localparam int DW = SUMW + 17;
  localparam int PBW = $clog2(DW);
  localparam int DSC = 32;
  localparam int PW = 48;
  localparam int SHW = 6;

  logic [15:0] mlut [65];
  logic [15:0] frl [DW];
  logic [SHW-1:0] shl [DW];

  for (genvar i = 0; i < 65; i++) begin : g_mant
    localparam real MX = 1.0 + real'(i) / 64.0;
    localparam int MV = $rtoi((MX ** (-BETA)) * 32768.0 + 0.5);
    assign mlut[i] = 16'(MV);
  end

  for (genvar q = 0; q < DW; q++) begin : g_exp
    localparam real EX = (q >= DSC) ? BETA * real'(q - DSC) : 0.0;
    localparam int ES = $rtoi(EX);
    localparam int EF = $rtoi((2.0 ** (real'(ES) - EX)) * 32768.0 + 0.5);
    assign frl[q] = 16'(EF);
    assign shl[q] = SHW'(ES);
  end

  function automatic logic [31:0] sq(input logic signed [15:0] v);
    logic signed [31:0] w;
    w = v * v;
    return w;
  endfunction

  logic signed [15:0] pad [PADN];
  logic busy;
  logic [CW-1:0] cnt;
  logic [GW-1:0] grp;

  assign in_ready = !busy;
  wire take = in_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt <= '0;
      grp <= '0;
      for (int x = 0; x < PADN; x++) pad[x] <= '0;
    end else if (!busy) begin
      if (take) begin
        for (int x = 0; x < MAPS + HALF - 1; x++) pad[x] <= pad[x+1];
        pad[MAPS+HALF-1] <= in_pixel;
        if (cnt == CW'(MAPS - 1)) begin
          cnt <= '0;
          busy <= 1'b1;
          grp <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (grp == GW'(GRPS - 1)) begin
      busy <= 1'b0;
      for (int x = 0; x < PADN; x++) pad[x] <= '0;
    end else begin
      grp <= grp + 1'b1;
      for (int x = 0; x < PADN; x++) pad[x] <= (x + LANES < PADN) ? pad[(x+LANES) % PADN] : '0;
    end
  end

  logic [SUMW-1:0] sum_c [LANES];

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      sum_c[j] = '0;
      for (int d = 0; d < WIN; d++) sum_c[j] = sum_c[j] + SUMW'(sq(pad[(j+d) % PADN]));
    end
  end

  logic s1_v;
  logic [MW-1:0] s1_first;
  logic [LANES-1:0] s1_mask;
  logic [SUMW-1:0] s1_sum [LANES];
  logic signed [15:0] s1_a [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s1_first <= '0;
      s1_mask <= '0;
      for (int j = 0; j < LANES; j++) begin
        s1_sum[j] <= '0;
        s1_a[j] <= '0;
      end
    end else begin
      s1_v <= busy;
      s1_first <= MW'(int'(grp) * LANES);
      for (int j = 0; j < LANES; j++) begin
        s1_mask[j] <= busy && (int'(grp) * LANES + j < MAPS);
        s1_sum[j] <= sum_c[j];
        s1_a[j] <= pad[(j+HALF) % PADN];
      end
    end
  end

  logic [DW-1:0] dv_c [LANES];
  logic [PBW-1:0] lead_c [LANES];
  logic [13:0] top_c [LANES];
  logic [15:0] lo_c [LANES];
  logic [15:0] hi_c [LANES];
  logic [23:0] dl_c [LANES];
  logic [15:0] m_c [LANES];

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      dv_c[j] = (DW'(K_FIX) << (DSC - 8)) + DW'(ALPHA_FIX) * DW'(s1_sum[j]);
      lead_c[j] = '0;
      for (int b = 0; b < DW; b++) if (dv_c[j][b]) lead_c[j] = PBW'(b);
      top_c[j] = 14'((dv_c[j] << (DW - 1 - int'(lead_c[j]))) >> (DW - 15));
      lo_c[j] = mlut[{1'b0, top_c[j][13:8]}];
      hi_c[j] = mlut[{1'b0, top_c[j][13:8]} + 7'd1];
      dl_c[j] = 24'(lo_c[j] - hi_c[j]) * 24'(top_c[j][7:0]);
      m_c[j] = lo_c[j] - 16'(dl_c[j] >> 8);
    end
  end

  logic s2_v;
  logic [MW-1:0] s2_first;
  logic [LANES-1:0] s2_mask;
  logic signed [15:0] s2_a [LANES];
  logic [15:0] s2_m [LANES];
  logic [15:0] s2_fr [LANES];
  logic [SHW-1:0] s2_sh [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0;
      s2_first <= '0;
      s2_mask <= '0;
      for (int j = 0; j < LANES; j++) begin
        s2_a[j] <= '0;
        s2_m[j] <= '0;
        s2_fr[j] <= '0;
        s2_sh[j] <= '0;
      end
    end else begin
      s2_v <= s1_v;
      s2_first <= s1_first;
      s2_mask <= s1_mask;
      for (int j = 0; j < LANES; j++) begin
        s2_a[j] <= s1_a[j];
        s2_m[j] <= m_c[j];
        s2_fr[j] <= frl[lead_c[j]];
        s2_sh[j] <= shl[lead_c[j]];
      end
    end
  end

  logic signed [PW-1:0] prod_c [LANES];
  logic signed [PW-1:0] res_c [LANES];

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      prod_c[j] = s2_a[j] * $signed({1'b0, s2_m[j]}) * $signed({1'b0, s2_fr[j]});
      res_c[j] = prod_c[j] >>> (SHW'(30) + s2_sh[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_first <= '0;
      out_mask <= '0;
      out_pixel <= '0;
    end else begin
      out_valid <= s2_v;
      out_first <= s2_v ? s2_first : '0;
      out_mask <= s2_v ? s2_mask : '0;
      for (int j = 0; j < LANES; j++)
        out_pixel[16*j +: 16] <= (s2_v && s2_mask[j]) ? res_c[j][15:0] : 16'd0;
    end
  end
endmodule

// File: rtl/xmap_norm_chk.sv
module xmap_norm_chk #(
  parameter int MAPS = 8,
  parameter int LANES = 2,
  localparam int MW = (MAPS > 1) ? $clog2(MAPS) : 1,
  localparam int GRPS = (MAPS + LANES - 1) / LANES
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic [MW-1:0]       out_first,
  input logic [LANES-1:0]    out_mask,
  input logic [16*LANES-1:0] out_pixel
);
  int acc;
  int stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= 0;
      stall <= 0;
    end else begin
      if (in_valid && in_ready) acc <= (acc == MAPS - 1) ? 0 : acc + 1;
      stall <= in_ready ? 0 : stall + 1;
    end
  end

  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mask[0] && ((out_mask & (out_mask + 1'b1)) == '0))); // R4
  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_mask == '0)); // R4
  AST_FIRST_GROUP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(out_valid)) |-> (out_first == '0)); // R4
  AST_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> (int'(out_first) == int'($past(out_first)) + LANES)); // R4
  AST_STALL_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> (stall == GRPS)); // R5
  AST_DROP_READY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && acc == MAPS - 1) |=> !in_ready); // R5

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    AST_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !out_mask[j] |-> (out_pixel[16*j +: 16] == 16'd0)); // R3
  end
endmodule

bind xmap_norm xmap_norm_chk #(.MAPS(MAPS), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_first(out_first), .out_mask(out_mask),
  .out_pixel(out_pixel));

// File: tb/tb_xmap_norm.sv
module tb_xmap_norm;
  localparam int CLK_PERIOD = 10;
  localparam int MAPS = 8;
  localparam int WIN = 5;
  localparam int LANES = 3;
  localparam int HALF = 2;
  localparam int GRPS = 3;
  localparam int MW = 3;
  localparam logic [15:0] KF = 16'h0200;
  localparam logic [15:0] AF = 16'h2000;
  localparam real BETA = 0.75;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_pixel = '0;
  logic in_ready;
  logic out_valid;
  logic [MW-1:0] out_first;
  logic [LANES-1:0] out_mask;
  logic [16*LANES-1:0] out_pixel;

  xmap_norm #(.MAPS(MAPS), .WIN(WIN), .LANES(LANES), .K_FIX(KF), .ALPHA_FIX(AF), .BETA(BETA)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pixel(in_pixel), .in_ready(in_ready),
    .out_valid(out_valid), .out_first(out_first), .out_mask(out_mask), .out_pixel(out_pixel));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  int rx_cycles = 0;
  logic [LANES-1:0] last_mask = '0;
  logic signed [15:0] rx_val [64];
  int rx_map [64];
  logic signed [15:0] stim [4][MAPS];

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      rx_cycles++;
      last_mask = out_mask;
      for (int l = 0; l < LANES; l++) begin
        if (out_mask[l]) begin
          if (rx_cnt < 64) begin
            rx_val[rx_cnt] = out_pixel[16*l +: 16];
            rx_map[rx_cnt] = int'(out_first) + l;
          end
          rx_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic real ref_val(input int pos, input int m);
    real s = 0.0;
    for (int j = m - HALF; j <= m + HALF; j++)
      if (j >= 0 && j < MAPS) s += real'(stim[pos][j]) * real'(stim[pos][j]) / 65536.0;
    return real'(stim[pos][m]) * ((real'(KF) / 256.0 + real'(AF) / 65536.0 * s) ** (-BETA));
  endfunction

  task automatic feed(input int pos, input bit garbage, output int stalls);
    stalls = 0;
    for (int m = 0; m < MAPS; m++) begin
      @(negedge clk);
      while (!in_ready) begin
        in_valid = garbage; in_pixel = 16'sh7fff;
        @(negedge clk);
      end
      in_valid = 1'b1; in_pixel = stim[pos][m];
    end
    @(negedge clk);
    in_valid = garbage; in_pixel = 16'sh7fff;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_pixel = '0;
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 100 && rx_cnt < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic compare_pos(input int pos, input int base, input string req);
    for (int m = 0; m < MAPS; m++) begin
      real e = ref_val(pos, m);
      int a = int'(rx_val[base+m]);
      real d = real'(a) - e;
      if (d < 0.0) d = -d;
      chk(d <= 2.0 + 0.002 * ((e < 0.0) ? -e : e), req, a, $rtoi(e));
      chk(rx_map[base+m] == m, "R4 order", rx_map[base+m], m);
    end
  endtask

  task automatic start_rx();
    rx_cnt = 0; rx_cycles = 0;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R7 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_uniform();
    int st;
    for (int m = 0; m < MAPS; m++) stim[0][m] = 16'sd1024;
    start_rx(); feed(0, 1'b0, st); wait_rx(MAPS);
    chk(rx_cnt == MAPS, "R3 count", rx_cnt, MAPS);
    chk(rx_cycles == GRPS, "R4 cycles", rx_cycles, GRPS);
    chk(last_mask == 3'b011, "R4 last mask", int'(last_mask), 3);
    compare_pos(0, 0, "R1 uniform");
  endtask

  task automatic t_spikes();
    int st;
    for (int m = 0; m < MAPS; m++) begin
      stim[0][m] = 16'sd256; stim[1][m] = 16'sd512;
    end
    stim[0][0] = 16'sd2048;
    stim[1][MAPS-1] = -16'sd3072;
    start_rx(); feed(0, 1'b0, st); wait_rx(MAPS);
    compare_pos(0, 0, "R2 low edge");
    start_rx(); feed(1, 1'b0, st); wait_rx(MAPS);
    compare_pos(1, 0, "R2 high edge");
  endtask

  task automatic t_signed();
    int st;
    stim[0] = '{-16'sd1536, 16'sd0, 16'sd768, -16'sd300, 16'sd0, 16'sd2000, -16'sd5, 16'sd100};
    start_rx(); feed(0, 1'b0, st); wait_rx(MAPS);
    compare_pos(0, 0, "R1 mixed");
    chk(rx_val[1] == 16'sd0, "R8 zero map1", int'(rx_val[1]), 0);
    chk(rx_val[4] == 16'sd0, "R8 zero map4", int'(rx_val[4]), 0);
    chk(rx_val[0] <= 0 && rx_val[0] >= -16'sd1536, "R8 negative map0", int'(rx_val[0]), -1);
    chk(rx_val[3] <= 0 && rx_val[3] >= -16'sd300, "R8 negative map3", int'(rx_val[3]), -1);
  endtask

  task automatic t_fullscale();
    int st;
    for (int m = 0; m < MAPS; m++) stim[2][m] = (m % 2 == 0) ? 16'sh7fff : -16'sh8000;
    start_rx(); feed(2, 1'b0, st); wait_rx(MAPS);
    compare_pos(2, 0, "R9 full scale");
  endtask

  task automatic t_backpressure();
    int st;
    for (int m = 0; m < MAPS; m++) stim[3][m] = 16'(200 * (m + 1));
    start_rx(); feed(3, 1'b1, st); wait_rx(MAPS);
    chk(st == GRPS, "R5 stall length", st, GRPS);
    chk(rx_cnt == MAPS, "R5 ignored input count", rx_cnt, MAPS);
    compare_pos(3, 0, "R5 ignored input values");
  endtask

  task automatic t_back_to_back();
    int st;
    for (int m = 0; m < MAPS; m++) begin
      stim[0][m] = 16'sd128; stim[1][m] = 16'sd640;
    end
    stim[0][0] = 16'sh7fff;
    stim[0][MAPS-1] = 16'sh7fff;
    start_rx(); feed(0, 1'b0, st); feed(1, 1'b0, st); wait_rx(2 * MAPS);
    chk(rx_cnt == 2 * MAPS, "R6 count", rx_cnt, 2 * MAPS);
    compare_pos(0, 0, "R6 first position");
    compare_pos(1, MAPS, "R6 second position");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_uniform();
    t_spikes();
    t_signed();
    t_fullscale();
    t_backpressure();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule